// File: doc/BRIEF.md
# Key-Sequence Guarded Configuration Register Bank

This block holds a bank of sixteen 8-bit configuration registers. The bank is hidden behind an unlock sequence on a fixed I/O port. While the bank is locked, every access to that port belongs to the ordinary device function, and the bank can neither be read nor written. Two consecutive writes of the unlock byte to the index port open the bank. While the bank is open, the index port holds a register number and the port directly above it reads and writes the selected register. Writing the exit byte to the index port closes the bank again.

The whole bank is also driven out in parallel, so that the neighbouring decode logic can use the settings at all times. A mode flag tells the ordinary function when it must release the two ports. Reset loads the default values, and one register is fixed to a read-only identity value.

Top module: `cfg_unlock`

## Requirements
- R1: After reset, `cfg_mode` is 0 and the bank holds these values: register 0 = 3Bh, register 1 = 9Fh, register 2 = DCh, register 3 = 78h, register 6 = FFh, register 13 = 65h. Every other register holds 00h. The selected index is 00h.
- R2: The bank opens when two writes of 55h are made to port 3F0h with no other bus access between them. Cycles with no access do not count as accesses. `cfg_mode` is 1 from the clock edge after the second write.
- R3: After a single 55h write, any other bus access clears the partial match. This covers a write of any other byte to 3F0h, a read of any port, and a write to any other port. After such an access, two new consecutive 55h writes are needed to open the bank.
- R4: While `cfg_mode` is 0, `cfg_regs` does not change, whatever is written to 3F0h, 3F1h or any other port. Reads return `rd_valid` = 0 and `rd_data` = 00h.
- R5: While the bank is open, a write of any byte other than AAh to 3F0h sets the index to that byte. A 55h write is treated as an index write in this state. A read of 3F0h returns the index.
- R6: While the bank is open and the index is below 10h, a write to 3F1h stores the byte in the selected register. A read of 3F1h returns that register. Read data and `rd_valid` = 1 appear on the clock edge after the read strobe.
- R7: Register 13 always reads 65h. Writes to it are ignored.
- R8: With an index of 10h or above, reads of 3F1h return 00h and writes to 3F1h change no register.
- R9: Writing AAh to 3F0h while the bank is open sets `cfg_mode` to 0 on the next edge and resets the index to 00h. The register contents are kept.
- R10: `cfg_regs` carries register n on bits [8n+7:8n]. A write shows on it from the clock edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 10 | I/O address of the current access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data for the index or data port |
| rd_valid | output | 1 | Set when `rd_data` answers a read of the bank while it is open |
| cfg_mode | output | 1 | High while the bank is open; the ordinary function must release both ports |
| cfg_regs | output | 128 | All sixteen registers, register n on bits [8n+7:8n] |

## Verification
The unlock detector is tried with 55h followed by each of the 256 possible second bytes. Exactly one of them may open the bank, so a comparison on the wrong byte or a missing second match is exposed. Separate patterns insert a read, a foreign-port write or idle cycles between the two key writes, which tells an access-based reset of the match apart from a cycle-based one. An index sweep over 00h to 1Fh writes a distinct computed byte through the data port and reads every index back. This separates the writable registers, the identity register and the out-of-range indexes. Writes made while the bank is locked, and a close followed by a reopen, show that the bank is frozen outside the mode and that its contents survive a close.

// File: rtl/cfgkey_pkg.sv
package cfgkey_pkg;

  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lk_state_t;

  // Reset value of each configuration register
  function automatic logic [7:0] cr_default(input int idx);
    case (idx)
      0:       cr_default = 8'h3B;
      1:       cr_default = 8'h9F;
      2:       cr_default = 8'hDC;
      3:       cr_default = 8'h78;
      6:       cr_default = 8'hFF;
      default: cr_default = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfgkey_seq.sv
// Unlock sequencer: counts consecutive key writes, opens and closes the bank.
module cfgkey_seq
  import cfgkey_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic acc_any,   // any bus access this cycle
  input  logic key_wr,    // key byte written to the index port
  input  logic exit_wr,   // exit byte written to the index port
  output logic open_o
);

  lk_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      LK_SHUT: if (key_wr) st_d = LK_HALF;
      LK_HALF: if (acc_any) st_d = key_wr ? LK_OPEN : LK_SHUT;
      LK_OPEN: if (exit_wr) st_d = LK_SHUT;
      default: st_d = LK_SHUT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= LK_SHUT;
    else     st_q <= st_d;
  end

  assign open_o = (st_q == LK_OPEN);

endmodule

// File: rtl/cfgkey_bank.sv
// Register bank with per-register reset defaults and one read-only slot.
module cfgkey_bank
  import cfgkey_pkg::*;
#(
  parameter int         NREG   = 16,
  parameter int         RO_IDX = 13,
  parameter logic [7:0] RO_VAL = 8'h65,
  localparam int        IDX_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [7:0]        wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [7:0]        rdata,
  output logic [NREG*8-1:0] flat
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == RO_IDX) begin : g_ro
      assign flat[g*8 +: 8] = RO_VAL;
    end else begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk) begin
        if (rst)                                q <= cr_default(g);
        else if (we && (widx == IDX_W'(g)))     q <= wdata;
      end
      assign flat[g*8 +: 8] = q;
    end
  end

  assign rdata = flat[ridx*8 +: 8];

endmodule

// File: rtl/cfg_unlock.sv
// Top: port decode, index register, registered read path.
module cfg_unlock
  import cfgkey_pkg::*;
#(
  parameter int              ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] BASE_PORT = 10'h3F0,
  parameter logic [7:0]      KEY_BYTE  = 8'h55,
  parameter logic [7:0]      EXIT_BYTE = 8'hAA,
  parameter int              NREG      = 16,
  parameter int              RO_IDX    = 13,
  parameter logic [7:0]      RO_VAL    = 8'h65
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              cfg_mode,
  output logic [NREG*8-1:0] cfg_regs
);

  localparam int               IDX_W     = $clog2(NREG);
  localparam logic [ADDR_W-1:0] DATA_PORT = ADDR_W'(BASE_PORT + 1'b1);

  logic is_idx, is_dat, open_s;
  logic key_wr, exit_wr, acc_any;
  logic [7:0] idx_q;
  logic idx_ok;
  logic bank_we;
  logic [7:0] bank_rd;

  assign is_idx  = (bus_addr == BASE_PORT);
  assign is_dat  = (bus_addr == DATA_PORT);
  assign acc_any = bus_wr | bus_rd;
  assign key_wr  = bus_wr & is_idx & (bus_wdata == KEY_BYTE);
  assign exit_wr = bus_wr & is_idx & (bus_wdata == EXIT_BYTE);
  assign idx_ok  = ((idx_q >> IDX_W) == 8'd0);

  cfgkey_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .acc_any (acc_any),
    .key_wr  (key_wr),
    .exit_wr (exit_wr),
    .open_o  (open_s)
  );

  // Index register: written while open, cleared on exit
  always_ff @(posedge clk) begin
    if (rst)                               idx_q <= 8'h00;
    else if (open_s && exit_wr)            idx_q <= 8'h00;
    else if (open_s && bus_wr && is_idx)   idx_q <= bus_wdata;
  end

  assign bank_we = open_s & bus_wr & is_dat & idx_ok;

  cfgkey_bank #(
    .NREG   (NREG),
    .RO_IDX (RO_IDX),
    .RO_VAL (RO_VAL)
  ) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (bank_we),
    .widx  (idx_q[IDX_W-1:0]),
    .wdata (bus_wdata),
    .ridx  (idx_q[IDX_W-1:0]),
    .rdata (bank_rd),
    .flat  (cfg_regs)
  );

  // Registered read response
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= 8'h00;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= open_s & bus_rd & (is_idx | is_dat);
      if (open_s && bus_rd && is_idx)      rd_data <= idx_q;
      else if (open_s && bus_rd && is_dat) rd_data <= idx_ok ? bank_rd : 8'h00;
      else                                 rd_data <= 8'h00;
    end
  end

  assign cfg_mode = open_s;

endmodule

// File: rtl/cfg_unlock_chk.sv
module cfg_unlock_chk #(
  parameter int                ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] BASE_PORT = 10'h3F0,
  parameter logic [7:0]        KEY_BYTE  = 8'h55,
  parameter logic [7:0]        EXIT_BYTE = 8'hAA,
  parameter int                NREG      = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        rd_data,
  input logic              rd_valid,
  input logic              cfg_mode,
  input logic [NREG*8-1:0] cfg_regs
);

  logic key_now, key_prev;
  assign key_now = bus_wr && (bus_addr == BASE_PORT) && (bus_wdata == KEY_BYTE);

  // Tracks whether the last bus access was a key write
  always_ff @(posedge clk) begin
    if (rst)                  key_prev <= 1'b0;
    else if (bus_wr || bus_rd) key_prev <= key_now;
  end

  assert_enter_on_key_pair_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_mode) |-> $past(key_prev && key_now));

  assert_exit_on_byte_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(cfg_mode) |-> $past(bus_wr && (bus_addr == BASE_PORT) && (bus_wdata == EXIT_BYTE)));

  assert_bank_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    !cfg_mode |=> $stable(cfg_regs));

  assert_read_only_open_R6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(cfg_mode && bus_rd &&
                       ((bus_addr == BASE_PORT) || (bus_addr == ADDR_W'(BASE_PORT + 1'b1)))));

  assert_idle_rd_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_data == 8'h00));

endmodule

bind cfg_unlock cfg_unlock_chk #(
  .ADDR_W    (ADDR_W),
  .BASE_PORT (BASE_PORT),
  .KEY_BYTE  (KEY_BYTE),
  .EXIT_BYTE (EXIT_BYTE),
  .NREG      (NREG)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .cfg_mode  (cfg_mode),
  .cfg_regs  (cfg_regs)
);

// File: tb/tb_cfg_unlock.sv
module tb_cfg_unlock;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [9:0]   bus_addr = 10'h000;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [7:0]   bus_wdata = 8'h00;
  logic [7:0]   rd_data;
  logic         rd_valid;
  logic         cfg_mode;
  logic [127:0] cfg_regs;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_cr [16];

  always #10 clk = ~clk;

  cfg_unlock dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .cfg_mode(cfg_mode), .cfg_regs(cfg_regs)
  );

  function automatic logic [7:0] def_val(input int i);
    case (i)
      0: return 8'h3B; 1: return 8'h9F; 2: return 8'hDC; 3: return 8'h78;
      6: return 8'hFF; 13: return 8'h65; default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic check_bank(input string req);
    for (int i = 0; i < 16; i++) check(req, cfg_regs[i*8 +: 8], exp_cr[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic v;
    for (int i = 0; i < 16; i++) exp_cr[i] = def_val(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 mode", {7'd0, cfg_mode}, 8'h00);
    check_bank("R1 defaults");

    // R4: locked writes and reads have no effect
    wr(10'h3F1, 8'h11); wr(10'h3F0, 8'h03); wr(10'h2F8, 8'h22);
    rd(10'h3F1, d, v);
    check("R4 rd_valid locked", {7'd0, v}, 8'h00);
    check("R4 rd_data locked", d, 8'h00);
    check_bank("R4 bank locked");

    // R2/R3: second byte sweep after one key write
    for (int b = 0; b < 256; b++) begin
      wr(10'h3F0, 8'h55);
      wr(10'h3F0, 8'(b));
      check("R2 R3 second byte", {7'd0, cfg_mode}, (b == 8'h55) ? 8'h01 : 8'h00);
      if (cfg_mode) wr(10'h3F0, 8'hAA);
    end

    // R3: intervening read
    wr(10'h3F0, 8'h55); rd(10'h3F0, d, v); wr(10'h3F0, 8'h55);
    check("R3 read between", {7'd0, cfg_mode}, 8'h00);
    wr(10'h3F0, 8'h55);
    check("R2 fresh pair after break", {7'd0, cfg_mode}, 8'h01);
    wr(10'h3F0, 8'hAA);
    // R3: intervening foreign-port write
    wr(10'h3F0, 8'h55); wr(10'h2F8, 8'h55); wr(10'h3F0, 8'h55);
    check("R3 other port between", {7'd0, cfg_mode}, 8'h00);
    wr(10'h3F0, 8'hAA);
    // R2: idle cycles between are not accesses
    wr(10'h3F0, 8'h55); repeat (5) @(negedge clk); wr(10'h3F0, 8'h55);
    check("R2 idle gap", {7'd0, cfg_mode}, 8'h01);

    // R5: index readback starts at 0
    rd(10'h3F0, d, v);
    check("R5 index start", d, 8'h00);
    check("R6 rd_valid open", {7'd0, v}, 8'h01);

    // R6/R7/R8/R10: write sweep over indexes 00h..1Fh
    for (int i = 0; i < 32; i++) begin
      logic [7:0] val;
      val = 8'(i * 37 + 5);
      wr(10'h3F0, 8'(i));
      wr(10'h3F1, val);
      if (i < 16 && i != 13) exp_cr[i] = val;
      check_bank("R10 bank after write");
    end
    for (int i = 0; i < 32; i++) begin
      logic [7:0] e;
      wr(10'h3F0, 8'(i));
      rd(10'h3F0, d, v);
      check("R5 index readback", d, 8'(i));
      rd(10'h3F1, d, v);
      e = (i < 16) ? exp_cr[i] : 8'h00;
      if (i == 13) check("R7 identity", d, 8'h65);
      else if (i >= 16) check("R8 out of range", d, 8'h00);
      else check("R6 readback", d, e);
    end

    // R5: key byte in open mode is an index write
    wr(10'h3F0, 8'h55);
    check("R5 stays open", {7'd0, cfg_mode}, 8'h01);
    rd(10'h3F0, d, v);
    check("R5 key as index", d, 8'h55);

    // R9: exit, contents kept, index cleared
    wr(10'h3F0, 8'h07);
    wr(10'h3F0, 8'hAA);
    check("R9 closed", {7'd0, cfg_mode}, 8'h00);
    wr(10'h3F1, 8'hEE);
    check_bank("R9 R4 kept after close");
    wr(10'h3F0, 8'h55); wr(10'h3F0, 8'h55);
    rd(10'h3F0, d, v);
    check("R9 index cleared", d, 8'h00);
    rd(10'h3F1, d, v);
    check("R9 contents kept", d, exp_cr[0]);
    wr(10'h3F0, 8'hAA);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule